// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

A clocked controller that gives a host a simple request/acknowledge port onto an external 128K x 8 asynchronous static RAM. The RAM has two chip selects of opposite polarity, an output enable, a write enable and one shared bidirectional 8-bit data bus. The controller produces every strobe from registers, drives the data bus only during writes, and holds each phase for a number of clock cycles derived at elaboration from nanosecond limits and the clock period.

Every phase length is ceil(t_ns / clock period), never less than one cycle, and is taken as the largest of the limits that bound that phase. Two sets of limits are built in, a fast set for the higher supply and a slow set for the lower supply. The `slow_i` pin picks the set for each access when it is accepted. After each access the RAM is deselected for a turnaround gap, so that its output drivers can float before the controller drives the bus again.

The host raises `req_i` with `we_i`, `addr_i` and `wdata_i` and keeps it high until `ack_o` pulses. A request that arrives while an access or a turnaround is still running waits until the controller is idle again.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and whenever idle, the RAM is in standby: `sram_cs1_no`=1, `sram_cs2_o`=0, `sram_oe_no`=1, `sram_we_no`=1, and the data bus is released.
- R2: A read holds `sram_cs1_no`=0, `sram_cs2_o`=1, `sram_oe_no`=0 and `sram_we_no`=1 for N_RD cycles, then latches the bus into `rdata_o` on the last of them. N_RD = max(ceil(read cycle / Tclk), ceil(OE access / Tclk)), which is 4 for the fast set at 20 ns. Bus data that only becomes valid in that last cycle must still be captured.
- R3: A write holds both selects active, `sram_we_no`=0 and `sram_oe_no`=1, and drives `wdata` onto the bus for N_WR cycles. N_WR is the maximum of the ceil counts for write cycle, write pulse, data setup and select-to-end, which is 4 for the fast set.
- R4: `ack_o` is high for exactly one cycle per access. From an idle controller, a request raised before clock edge 0 gives `ack_o` high after edge N, where N is N_RD or N_WR.
- R5: After each access the RAM stays deselected for at least N_HZ = ceil(bus release time / Tclk) cycles (2 at 20 ns) before it is selected again. The controller never drives the bus while `sram_oe_no` is low.
- R6: A request is accepted only when the controller is idle. A request held through an access is served once the turnaround has elapsed, so with the new request raised g cycles after the previous `ack_o`, the latency is N + max(1, 1 + N_HZ - g) cycles.
- R7: Address, write data, direction and timing set are captured at acceptance. Changing `addr_i`, `wdata_i` or `slow_i` later has no effect on the running access, and `sram_addr_o` stays stable while the RAM is selected.
- R8: With `slow_i`=1 at acceptance, the lower-supply limits apply. At 20 ns this gives N_RD = 5 and N_WR = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_i | input | 1 | 1 selects the lower-supply timing set |
| req_i | input | 1 | Access request, held until ack |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host address |
| wdata_i | input | 8 | Host write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid from the ack cycle |
| sram_addr_o | output | 17 | RAM address |
| sram_cs1_no | output | 1 | RAM select, active low |
| sram_cs2_o | output | 1 | RAM select, active high |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_dq_io | inout | 8 | RAM data bus |

## Verification
From an idle controller, `ack_o` is due N+1 sampled cycles after `req_i` rises. A request raised g cycles after the previous ack waits N + max(1, 1 + N_HZ - g) cycles. The bench computes both counts and compares them at the falling edge where the pulse must appear. The bench's RAM model counts falling edges of the active strobes. It returns real data only once the read has been held for N_RD cycles, and it checks write pulse length, address and data at the falling edge after `sram_we_no` rises. Any data read back is therefore correct only if the latch happens exactly on the due cycle. The deselect gap is counted the same way, in falling edges between one select and the next.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_TURN} st_e;

  function automatic int unsigned ns2cyc(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // expired timer stays expired until reloaded (phase lengths R2/R3)
  assert_timer_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  st_e  nxt_i,
  output logic cs1_no,
  output logic cs2_o,
  output logic oe_no,
  output logic we_no,
  output logic drv_o
);
  logic sel;
  assign sel = (nxt_i == ST_READ) || (nxt_i == ST_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs1_no <= 1'b1;
      cs2_o  <= 1'b0;
      oe_no  <= 1'b1;
      we_no  <= 1'b1;
      drv_o  <= 1'b0;
    end else begin
      cs1_no <= !sel;
      cs2_o  <= sel;
      oe_no  <= (nxt_i != ST_READ);
      we_no  <= (nxt_i != ST_WRITE);
      drv_o  <= (nxt_i == ST_WRITE);
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW      = 17,
  parameter int unsigned DW      = 8,
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned T_RC_F  = 70,
  parameter int unsigned T_OE_F  = 35,
  parameter int unsigned T_WC_F  = 70,
  parameter int unsigned T_WP_F  = 50,
  parameter int unsigned T_DW_F  = 30,
  parameter int unsigned T_CW_F  = 50,
  parameter int unsigned T_HZ_F  = 30,
  parameter int unsigned T_RC_S  = 100,
  parameter int unsigned T_OE_S  = 50,
  parameter int unsigned T_WC_S  = 100,
  parameter int unsigned T_WP_S  = 70,
  parameter int unsigned T_DW_S  = 50,
  parameter int unsigned T_CW_S  = 70,
  parameter int unsigned T_HZ_S  = 35
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_cs1_no,
  output logic          sram_cs2_o,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  inout  wire  [DW-1:0] sram_dq_io
);
  localparam int unsigned RD_F = umax(ns2cyc(T_RC_F, CLK_NS), ns2cyc(T_OE_F, CLK_NS));
  localparam int unsigned RD_S = umax(ns2cyc(T_RC_S, CLK_NS), ns2cyc(T_OE_S, CLK_NS));
  localparam int unsigned WR_F = umax(umax(ns2cyc(T_WC_F, CLK_NS), ns2cyc(T_WP_F, CLK_NS)),
                                      umax(ns2cyc(T_DW_F, CLK_NS), ns2cyc(T_CW_F, CLK_NS)));
  localparam int unsigned WR_S = umax(umax(ns2cyc(T_WC_S, CLK_NS), ns2cyc(T_WP_S, CLK_NS)),
                                      umax(ns2cyc(T_DW_S, CLK_NS), ns2cyc(T_CW_S, CLK_NS)));
  localparam int unsigned HZ   = umax(ns2cyc(T_HZ_F, CLK_NS), ns2cyc(T_HZ_S, CLK_NS));
  localparam int unsigned NMAX = umax(umax(RD_F, RD_S), umax(umax(WR_F, WR_S), HZ));
  localparam int unsigned CW   = $clog2(NMAX + 1);
  localparam logic [CW-1:0] RD_F_L = CW'(RD_F - 1);
  localparam logic [CW-1:0] RD_S_L = CW'(RD_S - 1);
  localparam logic [CW-1:0] WR_F_L = CW'(WR_F - 1);
  localparam logic [CW-1:0] WR_S_L = CW'(WR_S - 1);
  localparam logic [CW-1:0] HZ_L   = CW'(HZ - 1);

  st_e           st_q, st_d;
  logic          load, done, drv;
  logic [CW-1:0] load_val;
  logic [DW-1:0] wdata_q;
  logic          accept;

  assign accept = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        load = 1'b1;
        if (we_i) begin
          st_d     = ST_WRITE;
          load_val = slow_i ? WR_S_L : WR_F_L;
        end else begin
          st_d     = ST_READ;
          load_val = slow_i ? RD_S_L : RD_F_L;
        end
      end
      ST_READ, ST_WRITE: if (done) begin
        st_d     = ST_TURN;
        load     = 1'b1;
        load_val = HZ_L;
      end
      ST_TURN: if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sram_addr_o <= '0;
      wdata_q     <= '0;
      ack_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      st_q  <= st_d;
      ack_o <= ((st_q == ST_READ) || (st_q == ST_WRITE)) && done;
      if (accept) begin
        sram_addr_o <= addr_i;
        wdata_q     <= wdata_i;
      end
      if ((st_q == ST_READ) && done) rdata_o <= sram_dq_io;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_strobe_gen u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (st_d),
    .cs1_no (sram_cs1_no),
    .cs2_o  (sram_cs2_o),
    .oe_no  (sram_oe_no),
    .we_no  (sram_we_no),
    .drv_o  (drv)
  );

  assign sram_dq_io = drv ? wdata_q : 'z;

  assert_idle_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (sram_cs1_no && !sram_cs2_o && sram_oe_no && sram_we_no && !drv));
  assert_read_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ) |-> (!sram_cs1_no && sram_cs2_o && !sram_oe_no && sram_we_no));
  assert_write_strobes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WRITE) |-> (!sram_cs1_no && sram_cs2_o && sram_oe_no && !sram_we_no && drv));
  assert_ack_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_turn_deselect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TURN) |-> (sram_cs1_no && !sram_cs2_o && !drv));
  assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv |-> sram_oe_no);
  assert_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs1_no && $past(!sram_cs1_no)) |-> $stable(sram_addr_o));
endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni, slow_i, req_i, we_i;
  logic [16:0] addr_i, sram_addr_o;
  logic [7:0]  wdata_i, rdata_o;
  logic        ack_o, sram_cs1_no, sram_cs2_o, sram_oe_no, sram_we_no;
  wire  [7:0]  sram_dq_io;

  always #10 clk_i = ~clk_i;

  sram_ctrl dut (.*);

  int errors = 0, checks = 0;
  localparam int HZ = 2;

  function automatic int cyc(int t); return (t + 19) / 20; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int n_rd(bit s);
    return s ? mx(cyc(100), cyc(50)) : mx(cyc(70), cyc(35));
  endfunction
  function automatic int n_wr(bit s);
    return s ? mx(mx(cyc(100), cyc(70)), mx(cyc(50), cyc(70)))
             : mx(mx(cyc(70), cyc(50)), mx(cyc(30), cyc(50)));
  endfunction
  function automatic logic [7:0] dflt(logic [16:0] a);
    return a[7:0] ^ {a[15:8]} ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [7:0] model_mem [int];
  logic [7:0] ref_mem   [int];
  logic [7:0] m_q = 8'h00;
  bit         cur_slow = 0, r_slow = 0, w_slow = 0;
  logic [16:0] exp_addr = '0, w_exp_addr = '0;
  logic [7:0]  exp_wdata = '0, w_exp_data = '0;
  int rcnt = 0, wcnt = 0, desel = 1000;
  logic [7:0]  wlat = '0;
  logic [16:0] wadr = '0;

  logic rd_act, wr_act, sel;
  assign sel    = !sram_cs1_no && sram_cs2_o;
  assign rd_act = sel && !sram_oe_no && sram_we_no;
  assign wr_act = sel && !sram_we_no;
  assign sram_dq_io = rd_act ? m_q : 'z;

  function automatic logic [7:0] mlook(logic [16:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : dflt(a);
  endfunction

  always @(negedge clk_i) begin
    if (rd_act) begin
      if (rcnt == 0) r_slow = cur_slow;
      rcnt = rcnt + 1;
      m_q  = (rcnt >= n_rd(r_slow)) ? mlook(sram_addr_o) : (mlook(sram_addr_o) ^ 8'hA5);
    end else begin
      rcnt = 0;
      m_q  = mlook(sram_addr_o) ^ 8'hA5;
    end
    if (wr_act) begin
      if (wcnt == 0) begin
        w_slow = cur_slow; w_exp_addr = exp_addr; w_exp_data = exp_wdata;
      end
      wcnt = wcnt + 1;
      wlat = sram_dq_io;
      wadr = sram_addr_o;
    end else if (wcnt > 0) begin
      chk(wcnt >= n_wr(w_slow), "R3 write pulse cycles (R8 set)", wcnt, n_wr(w_slow));
      chk(wadr == w_exp_addr, "R7 write address", wadr, w_exp_addr);
      chk(wlat == w_exp_data, "R3 write data on bus", wlat, w_exp_data);
      model_mem[int'(wadr)] = wlat;
      wcnt = 0;
    end
    if (sel) begin
      if (desel > 0) chk(desel >= HZ, "R5 deselect gap", desel, HZ);
      desel = 0;
    end else if (desel < 1000) desel = desel + 1;
  end

  // ---------------- host tasks ----------------
  task automatic standby_chk(string tag);
    chk(sram_cs1_no == 1'b1, tag, sram_cs1_no, 1);
    chk(sram_cs2_o  == 1'b0, tag, sram_cs2_o, 0);
    chk(sram_oe_no  == 1'b1, tag, sram_oe_no, 1);
    chk(sram_we_no  == 1'b1, tag, sram_we_no, 1);
    chk(ack_o       == 1'b0, tag, ack_o, 0);
  endtask

  task automatic access(bit w, logic [16:0] a, logic [7:0] d, bit s, int g);
    int lat, acc, n;
    bit got;
    repeat (g) @(negedge clk_i);
    acc = mx(1, 1 + HZ - g);
    n   = w ? n_wr(s) : n_rd(s);
    cur_slow = s; exp_addr = a; exp_wdata = d;
    we_i = w; addr_i = a; wdata_i = d; slow_i = s; req_i = 1'b1;
    lat = 0; got = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk_i); lat++;
      @(negedge clk_i);
      if (lat == acc) begin  // R7: scramble inputs after acceptance
        addr_i = $urandom; wdata_i = $urandom; slow_i = ~s; we_i = ~w;
      end
      if (ack_o) begin got = 1; break; end
    end
    req_i = 1'b0;
    chk(got, "R6 ack arrived", got, 1);
    chk(lat == n + acc, w ? "R4/R6 write latency (R8 set)" : "R4/R6 read latency (R8 set)", lat, n + acc);
    if (!w) begin
      logic [7:0] e;
      e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
      chk(rdata_o == e, "R2 read data", rdata_o, e);
    end else ref_mem[int'(a)] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [16:0] pool [8];
    void'($urandom(32'h5EED_1234));
    rst_ni = 1'b0; slow_i = 0; req_i = 0; we_i = 0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    standby_chk("R1 reset standby");
    rst_ni = 1'b1;
    @(negedge clk_i);
    standby_chk("R1 idle after reset");

    // directed corners
    access(1, 17'h00000, 8'h3C, 0, 10);
    access(0, 17'h00000, 8'h00, 0, 0);     // R6 held request
    access(1, 17'h1FFFF, 8'hC3, 1, 1);     // R8 slow write, top address
    access(0, 17'h1FFFF, 8'h00, 1, 5);     // R8 slow read
    access(0, 17'h00777, 8'h00, 0, 2);     // unwritten location
    access(1, 17'h00777, 8'hFF, 1, 0);
    access(0, 17'h00777, 8'h00, 0, 0);
    repeat (4) @(negedge clk_i);
    standby_chk("R1 idle between accesses");

    for (int i = 0; i < 8; i++) pool[i] = $urandom;
    for (int i = 0; i < 120; i++) begin
      bit w = $urandom_range(0, 1);
      logic [16:0] a = ($urandom_range(0, 3) == 0) ? 17'($urandom) : pool[$urandom_range(0, 7)];
      access(w, a, 8'($urandom), bit'($urandom_range(0, 1)), $urandom_range(0, 4));
    end
    repeat (4) @(negedge clk_i);
    standby_chk("R1 final standby");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule